// File: doc/BRIEF.md
# Adaptive Bittree Symbol Decoder

This block pulls a multi-bit symbol out of an arithmetic-coded byte stream by resolving one binary decision per cycle. Every decision is weighted by an 11-bit adaptive probability. The entry used for a decision is picked from the part of the symbol already decoded, so each path through the tree has its own statistics. The probabilities live in a local table of 2^MAX_BITS entries. After every decision the table is updated toward the value just seen.

A forward tree yields N bits, most significant first, where N is 3, 6 or 8. The partial symbol carries a leading one, and that partial symbol is itself the table index. A reverse tree always yields four bits, least significant first. In that mode the index is the partial result plus a power-of-two offset for the current bit position. In both modes a 16-bit two's-complement constant is added to the finished symbol. This either removes the forward tree's leading one or adds a base value.

After reset the block loads the interval state from its first five bytes. It then waits for a start pulse that carries the tree configuration. It takes a new byte whenever the interval has grown too narrow, and it stalls while no byte is offered. When the symbol is complete it raises a one-cycle done pulse together with the result.

Top module: `rcbt_symbol_decoder`

## Requirements
- R1: Synchronous reset sets busy=1, done=0 and in_ready=1. The block then accepts exactly five bytes that form the 32-bit code value, first byte most significant and shifted out. The range is all ones, and busy then falls.
- R2: Forward mode (cfg_reverse=0) decodes exactly cfg_bits bits, for cfg_bits of 3, 6 or 8. The partial symbol starts at 1. Each bit b changes it to 2*s+b, and the probability for that bit is table entry s. The result is the final s (leading one included) plus cfg_add, modulo 2^16.
- R3: Reverse mode (cfg_reverse=1) decodes four bits, whatever cfg_bits holds. The partial result starts at 0. Bit k uses table entry s+2^k and adds 2^k to s when it is 1, so the first bit is the result's LSB. cfg_add is added as in R2.
- R4: Every table entry is 1024 after reset. A 0 decision sets p to p+((2048-p)>>5), and a 1 decision sets p to p-(p>>5). Each update is in place before that entry can be read again, including by later symbols.
- R5: A decision computes bound=(range>>11)*p. If code<bound the bit is 0 and range becomes bound. Otherwise the bit is 1 and both range and code drop by bound. While range<2^24, the next decision first takes one byte, which makes range=range<<8 and code=(code<<8)|byte.
- R6: in_ready is high only during the initial load or when a byte is needed. While in_valid is low at such a point, no state advances, and stall patterns have no effect on the results.
- R7: done is high for exactly one cycle, in the cycle after the last decision, with busy already low. sym_out holds the result until the next done.
- R8: A start pulse while busy is high is ignored. The running symbol finishes with its own configuration, and no second decode follows.
- R9: A reset in the middle of a symbol abandons it and restores R1 and the 1024 table contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one symbol, taken only when idle |
| cfg_reverse | input | 1 | 1 selects the four-bit reverse tree |
| cfg_bits | input | 4 | Forward tree depth |
| cfg_add | input | 16 | Constant added to the finished symbol |
| in_valid | input | 1 | A stream byte is offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| busy | output | 1 | Loading or decoding |
| done | output | 1 | One-cycle result strobe |
| sym_out | output | 16 | Decoded symbol after the final add |

## Verification
The assertions assume two things about the inputs. A start in forward mode carries a depth between 1 and MAX_BITS. The four code bytes after the leading byte are not all 0xFF, so code stays below range from the end of the load onward. The stimulus draws every depth from {3,6,8} and clears the top bit of the first code byte after each reset. It takes all other bytes, stall gaps, tree modes and add constants from a fixed-seed generator, alongside directed final-add cases, a start during a busy symbol, and a reset in the middle of a symbol.

// File: rtl/rcbt_pkg.sv
package rcbt_pkg;
    localparam int PROB_W     = 11;
    localparam int PROB_TOTAL = 1 << PROB_W;
    localparam int PROB_INIT  = PROB_TOTAL / 2;
    localparam int MOVE_SH    = 5;
    localparam int PROB_LO    = (1 << MOVE_SH) - 1;
    localparam int PROB_HI    = PROB_TOTAL - (1 << MOVE_SH) + 1;
    localparam int RANGE_W    = 32;
    localparam int BYTE_W     = 8;
    localparam int TOP_LOG    = 24;

    typedef logic [PROB_W-1:0]  prob_t;
    typedef logic [RANGE_W-1:0] word_t;

    typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_BIT} dec_state_e;

    typedef struct packed {
        word_t span;
        word_t code;
    } interval_t;

    function automatic prob_t adapt(prob_t p, logic b);
        prob_t delta_up;
        prob_t delta_dn;
        delta_up = prob_t'((PROB_TOTAL - int'(p)) >> MOVE_SH);
        delta_dn = p >> MOVE_SH;
        return b ? (p - delta_dn) : (p + delta_up);
    endfunction

    function automatic logic narrow(word_t span);
        return span < (word_t'(1) << TOP_LOG);
    endfunction
endpackage

// File: rtl/rcbt_prob_ram.sv
module rcbt_prob_ram
    import rcbt_pkg::*;
#(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr,
    output prob_t         rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  prob_t         wdata
);
    prob_t table_q [DEPTH];

    assign rdata = table_q[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                table_q[i] <= prob_t'(PROB_INIT);
            end
        end else if (we) begin
            table_q[waddr] <= wdata;
        end
    end

    // R4: adapted values stay inside the window the update rule allows from 1024
    assert_prob_window_R4: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(wdata) >= PROB_LO && int'(wdata) <= PROB_HI));
endmodule

// File: rtl/rcbt_bit_step.sv
module rcbt_bit_step
    import rcbt_pkg::*;
(
    input  interval_t cur,
    input  prob_t     prob,
    output logic      bit_val,
    output interval_t nxt,
    output prob_t     prob_nxt
);
    word_t bound;

    always_comb begin
        bound   = word_t'(cur.span[RANGE_W-1:PROB_W]) * word_t'(prob);
        bit_val = !(cur.code < bound);
        if (bit_val) begin
            nxt.span = cur.span - bound;
            nxt.code = cur.code - bound;
        end else begin
            nxt.span = bound;
            nxt.code = cur.code;
        end
        prob_nxt = adapt(prob, bit_val);
    end
endmodule

// File: rtl/rcbt_symbol_decoder.sv
module rcbt_symbol_decoder
    import rcbt_pkg::*;
#(
    parameter int MAX_BITS   = 8,
    parameter int REV_BITS   = 4,
    parameter int OUT_W      = 16,
    parameter int INIT_BYTES = 5,
    localparam int CNT_W     = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_reverse,
    input  logic [CNT_W-1:0]  cfg_bits,
    input  logic [OUT_W-1:0]  cfg_add,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic [OUT_W-1:0]  sym_out
);
    localparam int AW    = MAX_BITS;
    localparam int SYM_W = MAX_BITS + 1;
    localparam int IC_W  = $clog2(INIT_BYTES + 1);

    dec_state_e        state;
    interval_t         iv;
    logic [SYM_W-1:0]  sym;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  nbits;
    logic              rev_lat;
    logic [OUT_W-1:0]  add_lat;
    logic [IC_W-1:0]   init_cnt;

    logic              need_byte;
    logic              fire;
    logic              last;
    logic [AW-1:0]     idx;
    prob_t             prob_rd;
    prob_t             prob_wr;
    logic              bit_val;
    interval_t         iv_step;
    logic [SYM_W-1:0]  sym_next;

    assign need_byte = narrow(iv.span);
    assign in_ready  = (state == ST_INIT) || (state == ST_BIT && need_byte);
    assign busy      = (state != ST_IDLE);
    assign fire      = (state == ST_BIT) && !need_byte;
    assign last      = (cnt == CNT_W'(nbits - 1'b1));

    always_comb begin
        if (rev_lat) begin
            idx      = AW'(sym) + (AW'(1) << cnt);
            sym_next = sym | (SYM_W'(bit_val) << cnt);
        end else begin
            idx      = sym[AW-1:0];
            sym_next = {sym[SYM_W-2:0], bit_val};
        end
    end

    rcbt_prob_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .raddr (idx),
        .rdata (prob_rd),
        .we    (fire),
        .waddr (idx),
        .wdata (prob_wr)
    );

    rcbt_bit_step u_step (
        .cur      (iv),
        .prob     (prob_rd),
        .bit_val  (bit_val),
        .nxt      (iv_step),
        .prob_nxt (prob_wr)
    );

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state    <= ST_INIT;
            iv.span  <= '1;
            iv.code  <= '0;
            init_cnt <= '0;
            sym      <= '0;
            cnt      <= '0;
            nbits    <= '0;
            rev_lat  <= 1'b0;
            add_lat  <= '0;
            sym_out  <= '0;
        end else begin
            case (state)
                ST_INIT: begin
                    if (in_valid) begin
                        iv.code  <= {iv.code[RANGE_W-BYTE_W-1:0], in_data};
                        init_cnt <= init_cnt + 1'b1;
                        if (init_cnt == IC_W'(INIT_BYTES - 1)) state <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        rev_lat <= cfg_reverse;
                        nbits   <= cfg_reverse ? CNT_W'(REV_BITS) : cfg_bits;
                        add_lat <= cfg_add;
                        sym     <= cfg_reverse ? SYM_W'(0) : SYM_W'(1);
                        cnt     <= '0;
                        state   <= ST_BIT;
                    end
                end
                ST_BIT: begin
                    if (need_byte) begin
                        if (in_valid) begin
                            iv.span <= iv.span << BYTE_W;
                            iv.code <= {iv.code[RANGE_W-BYTE_W-1:0], in_data};
                        end
                    end else begin
                        iv  <= iv_step;
                        sym <= sym_next;
                        cnt <= cnt + 1'b1;
                        if (last) begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            sym_out <= OUT_W'(sym_next) + add_lat;
                        end
                    end
                end
                default: state <= ST_INIT;
            endcase
        end
    end

    // R7: the result strobe lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: the strobe coincides with the return to idle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R6: bytes are only requested while loading or decoding
    assert_ready_busy_R6: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);
    // R6: a missing byte freezes the partial symbol
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT && need_byte && !in_valid) |=> $stable(sym) && $stable(cnt));
    // R2: the decision counter never reaches the tree depth while decoding
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT) |-> (cnt < nbits));
    // R2: forward starts use a supported depth
    assert_cfg_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !cfg_reverse) |-> (cfg_bits != 0 && int'(cfg_bits) <= MAX_BITS));
    // R5: interval invariant once the code value is loaded
    assert_code_below_span_R5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_INIT) |-> (iv.code < iv.span));
    // R8: a start while busy does not restart the symbol
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT && start && !fire) |=> $stable(cnt));
endmodule

// File: tb/test_rcbt_symbol_decoder.sv
module test_rcbt_symbol_decoder;
    localparam int NSTREAM = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_reverse = 1'b0;
    logic [3:0]  cfg_bits = 4'd8;
    logic [15:0] cfg_add = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        busy;
    logic        done;
    logic [15:0] sym_out;

    always #2.5 clk = ~clk;

    rcbt_symbol_decoder i_rcbt_symbol_decoder (
        .clk(clk), .rst(rst), .start(start), .cfg_reverse(cfg_reverse),
        .cfg_bits(cfg_bits), .cfg_add(cfg_add), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done),
        .sym_out(sym_out)
    );

    logic [7:0]  stream [NSTREAM];
    int          ptr = 0;
    int          mptr = 0;
    bit          feed_en = 1'b0;
    int          stall_pct = 0;
    bit          v_q = 1'b0;
    bit          r_q = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    int unsigned m_span;
    int unsigned m_code;
    int          m_prob [256];

    // byte feeder: counts handshakes from the values stable across each edge
    initial begin
        forever begin
            @(negedge clk);
            if (v_q && r_q) ptr++;
            in_valid = feed_en && ($urandom_range(99) >= stall_pct);
            in_data  = stream[ptr];
            v_q = in_valid;
            r_q = in_ready;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_init();
        m_span = 32'hFFFF_FFFF;
        m_code = 0;
        for (int i = 0; i < 5; i++) begin
            m_code = (m_code << 8) | 32'(stream[mptr]);
            mptr++;
        end
        for (int i = 0; i < 256; i++) m_prob[i] = 1024;
    endfunction

    function automatic int mbit(int idx);
        int unsigned bound;
        int b;
        while (m_span < 32'h0100_0000) begin
            m_span = m_span << 8;
            m_code = (m_code << 8) | 32'(stream[mptr]);
            mptr++;
        end
        bound = (m_span >> 11) * 32'(m_prob[idx]);
        if (m_code < bound) begin
            b = 0;
            m_span = bound;
            m_prob[idx] = m_prob[idx] + ((2048 - m_prob[idx]) >> 5);
        end else begin
            b = 1;
            m_span = m_span - bound;
            m_code = m_code - bound;
            m_prob[idx] = m_prob[idx] - (m_prob[idx] >> 5);
        end
        return b;
    endfunction

    function automatic int model_sym(bit rev, int n, int add);
        int s;
        if (rev) begin
            s = 0;
            for (int k = 0; k < 4; k++) s = s | (mbit(s + (1 << k)) << k);
        end else begin
            s = 1;
            for (int k = 0; k < n; k++) s = (s << 1) | mbit(s);
        end
        return (s + add) & 16'hFFFF;
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset(int base);
        feed_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        ptr = base;
        mptr = base;
        stream[base + 1] = stream[base + 1] & 8'h7F;
        @(negedge clk);
        chk(busy == 1'b1 && in_ready == 1'b1 && done == 1'b0, "R1 reset state",
            {busy, in_ready, done}, 3'b110);
        rst = 1'b0;
        feed_en = 1'b1;
        model_init();
    endtask

    task automatic run_sym(bit rev, int n, int add, string req, bit poke);
        int exp;
        int guard;
        wait_idle();
        exp = model_sym(rev, n, add);
        cfg_reverse = rev;
        cfg_bits = 4'(n);
        cfg_add = 16'(add);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8: start with another configuration while the symbol runs
            cfg_reverse = !rev;
            cfg_bits = 4'd3;
            cfg_add = 16'h1234;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {req, " done seen"}, done, 1);
        chk(sym_out == 16'(exp), req, sym_out, exp);
        @(negedge clk);
        chk(done == 1'b0, "R7 done width", done, 0);
        chk(sym_out == 16'(exp), "R7 sym_out hold", sym_out, exp);
        if (poke) chk(busy == 1'b0, "R8 no second decode", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < NSTREAM; i++) stream[i] = 8'($urandom(32'd7) & 0);
        for (int i = 0; i < NSTREAM; i++) stream[i] = 8'($urandom);
        stream[0] = 8'h00;
        do_reset(0);
        begin
            int guard = 0;
            while (busy && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            chk(busy == 1'b0, "R1 load completes", busy, 0);
        end
        // directed final-add cases
        run_sym(1'b0, 8, 16'hFF00, "R2 fwd8 strip", 1'b0);
        run_sym(1'b0, 3, 16'hFFFA, "R2 fwd3 strip+base", 1'b0);
        run_sym(1'b0, 6, 0, "R2 fwd6 keep lead", 1'b0);
        run_sym(1'b1, 4, 0, "R3 rev4", 1'b0);
        run_sym(1'b1, 4, 100, "R3 rev4 base", 1'b0);
        // R8 start while busy
        run_sym(1'b0, 8, 16'hFF00, "R8 fwd8 poke", 1'b1);
        // R4 R5 adaptation across many symbols, free-running stream
        for (int i = 0; i < 150; i++) begin
            bit rv = ($urandom_range(3) == 0);
            int sel = $urandom_range(2);
            int n = (sel == 0) ? 3 : ((sel == 1) ? 6 : 8);
            int add = rv ? int'($urandom_range(15)) : ((-(1 << n) + int'($urandom_range(20))) & 16'hFFFF);
            run_sym(rv, n, add, rv ? "R3 R4 R5 random rev" : "R2 R4 R5 random fwd", 1'b0);
        end
        // R6 heavy stalls
        stall_pct = 75;
        for (int i = 0; i < 40; i++) begin
            bit rv = ($urandom_range(1) == 0);
            run_sym(rv, 8, 16'hFF00, "R6 stalled stream", 1'b0);
        end
        stall_pct = 0;
        // R9 reset in the middle of a symbol
        wait_idle();
        cfg_reverse = 1'b0;
        cfg_bits = 4'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        do_reset(6000);
        run_sym(1'b0, 8, 16'hFF00, "R9 after mid reset", 1'b0);
        run_sym(1'b1, 4, 0, "R9 R4 rev after reset", 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule